// File: doc/BRIEF.md
# Palette Memory Access Port

This block gives a processor byte-wide access to a palette memory of 256 entries, each holding a 15-bit colour. It has three registers, picked by a 2-bit select. One register sets the entry address. One takes write data. One returns read data. Each entry is wider than the data bus, so the port splits every word access into a low pass and a high pass. It keeps separate half-toggles for reads and for writes.

Writes are staged. The first data write holds its byte in a latch. The second data write stores the whole colour word and moves the address to the next entry. Reads return the low byte and then the high byte of the addressed entry, and the address moves on after the high byte.

The high colour byte has only seven meaningful bits. Its top bit is not driven from the memory. It is taken from an open-bus latch that holds the last byte this port returned. A caller streams a palette in or out by setting the address once and then issuing back-to-back data accesses.

Top module: `palette_port`

## Requirements
- R1: The select encoding is 0 for the address register, 1 for data write, 2 for data read and 3 for unused. A write strobe with select 0 loads wdata into the entry address and clears both the read half-toggle and the write half-toggle.
- R2: A read (rd_en with select 2) while the read toggle is clear returns entry bits 7:0 and leaves the address unchanged.
- R3: A read while the read toggle is set returns entry bits 14:8 on rdata[6:0]. rdata[7] is bit 7 of the open-bus latch. The address then advances by one.
- R4: Every read flips the read toggle, and every byte a read returns is captured into the open-bus latch.
- R5: A data write while the write toggle is clear only stages the byte. A data write while the write toggle is set stores {wdata[6:0], staged byte} into the addressed entry and advances the address. Every data write flips the write toggle.
- R6: Data writes leave the read toggle unchanged, and reads leave the write toggle unchanged.
- R7: The entry address wraps from 255 to 0 on both the read and the write paths.
- R8: A write strobe with select 2 or 3, and a read strobe with any select other than 2, change no state.
- R9: Reset clears the address to 0, clears both toggles and clears the open-bus latch.
- R10: Read data is combinational. It is valid in the same cycle as the read strobe, before the clock edge that advances the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 2 | Register select: 0 address, 1 data write, 2 data read, 3 unused |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe for the selected register |
| wdata | input | 8 | Byte written to the selected register |
| rdata | output | 8 | Byte returned by a data read |

## Verification
A single select means that at most one register action takes effect in a cycle. The properties therefore treat address loads, data writes and reads as mutually exclusive. A strobe on an unsupported select is expected to leave all state frozen. The stimulus drives one strobe per cycle from tasks, and it mixes in stray strobes only on selects that must be ignored. It also reads only entries that were written earlier, so every expected byte is defined.

// File: rtl/palette_port.sv
module palette_port #(
  parameter int ADDR_W  = 8,
  parameter int COLOR_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int HI_W    = COLOR_W - 8;
  localparam int KEEP_W  = 8 - HI_W;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_WDAT = 2'd1;
  localparam logic [1:0] SEL_RDAT = 2'd2;

  logic [COLOR_W-1:0] pal_mem [DEPTH];
  logic [ADDR_W-1:0]  addr_q;
  logic               rd_half;
  logic               wr_half;
  logic [7:0]         stage_q;
  logic [7:0]         bus_q;
  logic [COLOR_W-1:0] entry;

  wire addr_wr = wr_en && (reg_sel == SEL_ADDR);
  wire data_wr = wr_en && (reg_sel == SEL_WDAT);
  wire data_rd = rd_en && (reg_sel == SEL_RDAT);

  assign entry = pal_mem[addr_q];
  assign rdata = rd_half ? {bus_q[7 -: KEEP_W], entry[COLOR_W-1:8]} : entry[7:0];

  always_ff @(posedge clk) begin
    if (data_wr && wr_half)
      pal_mem[addr_q] <= {wdata[HI_W-1:0], stage_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rd_half <= 1'b0;
      wr_half <= 1'b0;
      stage_q <= '0;
      bus_q   <= '0;
    end else if (addr_wr) begin
      addr_q  <= wdata[ADDR_W-1:0];
      rd_half <= 1'b0;
      wr_half <= 1'b0;
    end else if (data_wr) begin
      wr_half <= ~wr_half;
      if (wr_half) addr_q  <= addr_q + 1'b1;
      else         stage_q <= wdata;
    end else if (data_rd) begin
      rd_half <= ~rd_half;
      bus_q   <= rdata;
      if (rd_half) addr_q <= addr_q + 1'b1;
    end
  end
endmodule

// File: rtl/palette_port_chk.sv
module palette_port_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_sel,
  input logic              wr_en,
  input logic              rd_en,
  input logic [7:0]        wdata,
  input logic [7:0]        rdata,
  input logic [ADDR_W-1:0] addr_q,
  input logic              rd_half,
  input logic              wr_half,
  input logic [7:0]        bus_q
);
  wire a_ld = wr_en && reg_sel == 2'd0;
  wire d_wr = wr_en && reg_sel == 2'd1;
  wire d_rd = rd_en && reg_sel == 2'd2;
  wire idle = !a_ld && !d_wr && !d_rd && (wr_en || rd_en);

  a_r1_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
    a_ld |=> addr_q == $past(wdata[ADDR_W-1:0]) && !rd_half && !wr_half);

  a_r2_low_read_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    d_rd && !rd_half |=> $stable(addr_q));

  a_r3_high_read_advances: assert property (@(posedge clk) disable iff (!rst_n)
    d_rd && rd_half |=> addr_q == ADDR_W'($past(addr_q) + 1'b1));

  a_r4_read_toggle_flip: assert property (@(posedge clk) disable iff (!rst_n)
    d_rd |=> rd_half != $past(rd_half));

  a_r4_bus_capture: assert property (@(posedge clk) disable iff (!rst_n)
    d_rd |=> bus_q == $past(rdata));

  a_r5_commit_advances: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr && wr_half |=> addr_q == ADDR_W'($past(addr_q) + 1'b1) && !wr_half);

  a_r5_stage_holds_addr: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr && !wr_half |=> $stable(addr_q) && wr_half);

  a_r6_write_keeps_read_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    d_wr |=> $stable(rd_half));

  a_r6_read_keeps_write_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    d_rd |=> $stable(wr_half));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    d_rd && rd_half && (&addr_q) |=> addr_q == '0);

  a_r8_ignored_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    idle |=> $stable(addr_q) && $stable(rd_half) && $stable(wr_half) && $stable(bus_q));
endmodule

bind palette_port palette_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .rdata(rdata), .addr_q(addr_q), .rd_half(rd_half),
  .wr_half(wr_half), .bus_q(bus_q)
);

// File: tb/palette_port_tb.sv
module palette_port_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] reg_sel;
  logic       wr_en;
  logic       rd_en;
  logic [7:0] wdata;
  logic [7:0] rdata;

  palette_port u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
    .rd_en(rd_en), .wdata(wdata), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [14:0] m_mem [256];
  logic [7:0]  m_addr;
  logic        m_rt, m_wt;
  logic [7:0]  m_stage, m_bus;
  logic [7:0]  exp_q [$];
  string       tag_q [$];
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && rd_en && reg_sel == 2'd2) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL unexpected read: actual %02h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s: actual %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    wr_en = 0; rd_en = 0;
  endtask

  task automatic t_addr(input logic [7:0] a);
    reg_sel = 2'd0; wr_en = 1; wdata = a;
    m_addr = a; m_rt = 0; m_wt = 0;
    cyc();
  endtask

  task automatic t_wr(input logic [7:0] b);
    reg_sel = 2'd1; wr_en = 1; wdata = b;
    if (!m_wt) m_stage = b;
    else begin
      m_mem[m_addr] = {b[6:0], m_stage};
      m_addr = m_addr + 8'd1;
    end
    m_wt = !m_wt;
    cyc();
  endtask

  task automatic t_rd(input string tag);
    logic [7:0] e;
    e = m_rt ? {m_bus[7], m_mem[m_addr][14:8]} : m_mem[m_addr][7:0];
    exp_q.push_back(e); tag_q.push_back(tag);
    m_bus = e;
    if (m_rt) m_addr = m_addr + 8'd1;
    m_rt = !m_rt;
    reg_sel = 2'd2; rd_en = 1;
    cyc();
  endtask

  task automatic t_noise(input logic [1:0] s, input logic w, input logic r, input logic [7:0] d);
    reg_sel = s; wr_en = w; rd_en = r; wdata = d;
    cyc();
  endtask

  initial begin
    rst_n = 0; reg_sel = 0; wr_en = 0; rd_en = 0; wdata = 0;
    m_addr = 0; m_rt = 0; m_wt = 0; m_stage = 0; m_bus = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R9: reset leaves address 0 and write toggle clear
    t_wr(8'hA5); t_wr(8'h7F);
    t_addr(8'h00);
    t_rd("R9 reset addr low"); t_rd("R9 R3 high bit7 from bus");

    // R5 streaming writes, R2/R3/R4 reads, R10 same-cycle data
    t_addr(8'd10);
    t_wr(8'h12); t_wr(8'h34);
    t_wr(8'h80); t_wr(8'hFF);
    t_wr(8'h7E); t_wr(8'h01);
    t_wr(8'hC3); t_wr(8'h5A);
    t_addr(8'd10);
    for (int i = 0; i < 8; i++) t_rd("R2 R3 R4 R10 stream");

    // R7 wrap on write and read
    t_addr(8'd255);
    t_wr(8'h9C); t_wr(8'h2B);
    t_wr(8'h44); t_wr(8'h66);
    t_addr(8'd255);
    for (int i = 0; i < 4; i++) t_rd("R7 wrap");

    // R1 address write clears write toggle mid-pair
    t_addr(8'd20); t_wr(8'h11);
    t_addr(8'd20); t_wr(8'h22); t_wr(8'hB3);
    t_addr(8'd20);
    t_rd("R1 write toggle cleared lo"); t_rd("R1 write toggle cleared hi");

    // R1 address write clears read toggle mid-pair
    t_addr(8'd10); t_rd("R1 lo");
    t_addr(8'd11); t_rd("R1 read toggle cleared");
    t_rd("R1 hi");

    // R6 toggles independent
    t_addr(8'd10);
    t_wr(8'h55);
    t_rd("R6 low read between writes");
    t_wr(8'h06);
    t_rd("R6 high read of next entry");
    t_addr(8'd10);
    t_rd("R6 committed lo"); t_rd("R6 committed hi");

    // R8 ignored strobes
    t_addr(8'd12);
    t_rd("R8 before noise");
    t_noise(2'd2, 1'b1, 1'b0, 8'h00);
    t_noise(2'd3, 1'b1, 1'b1, 8'hEE);
    t_noise(2'd1, 1'b0, 1'b1, 8'h77);
    t_noise(2'd0, 1'b0, 1'b1, 8'h33);
    t_rd("R8 after noise hi");
    t_rd("R8 next entry lo");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10: %0d reads not observed, expected 0", exp_q.size());
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule